// File: doc/BRIEF.md
# Interrupt CPU Interface with Split End-of-Interrupt

This block is the per-processor face of an interrupt controller. It takes a vector of level-sensitive pending requests, each with a fixed priority on a side input, and raises one IRQ line toward the processor whenever some request can preempt the work already in progress. Software drives it through four 32-bit registers on a simple request/write bus: a control register, an acknowledge register that claims the winning interrupt, a priority-drop register and a deactivate register.

Ending an interrupt can be done in one step or two. With split mode off, one write to the drop register lowers the running priority and frees the interrupt. With split mode on, that write only lowers the running priority. The interrupt stays active, so it cannot be taken again, while other interrupts at its priority can. A later write to the deactivate register frees it. This lets a hypervisor drop priority at once and leave deactivation to a guest.

A running-priority stack of STACK_DEPTH entries records each claimed interrupt's ID and priority. A small state machine tracks how full it is: ST_IDLE (empty), ST_NESTED (one or more entries, not full) and ST_FULL. An acknowledge takes ST_IDLE to ST_NESTED, and takes ST_NESTED to ST_FULL when it fills the last slot. A matching drop takes ST_FULL to ST_NESTED, and takes ST_NESTED to ST_IDLE when it empties the stack.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, irq_o is low, the control register reads 0, and an acknowledge read returns 1023.
- R2: irq_o is high only when control bit 0 (enable) is set and some request is pending, not active, and numerically lower in priority than the running priority. The running priority is 16 when the stack is empty, and otherwise the priority on top of the stack. While bit 0 is clear, irq_o is low and acknowledge reads return 1023.
- R3: Among eligible requests the lowest priority value wins, and on equal priority the lower ID wins.
- R4: A read at offset 0x00C (acknowledge) returns the winner's ID in bits 9:0 with all other bits zero, one cycle after the request. It marks the winner active and pushes its ID and priority onto the stack. With nothing to take it returns 1023 and changes nothing, and it never returns 1020.
- R5: Only a strictly higher priority (lower value) preempts. When STACK_DEPTH interrupts are nested, irq_o is low and acknowledge returns 1023 until a drop frees a slot.
- R6: With control bit 9 (split) at 0, a write to offset 0x010 (drop) naming the top-of-stack ID pops the stack and makes that interrupt inactive, so a still-pending request is taken again.
- R7: With bit 9 at 1, the same drop write pops the stack but leaves the interrupt active and unsignalled, while other requests at the same priority become eligible.
- R8: A write at offset 0x1000 (deactivate) with an ID in bits 9:0 makes that interrupt inactive only when bit 9 is 1 and the interrupt is active. With bit 9 at 0 the write has no effect.
- R9: A drop write whose ID differs from the top-of-stack ID, or that arrives with an empty stack, is ignored.
- R10: The control register at offset 0x000 keeps bit 0, bits 8:5 and bit 9 as written, and reads 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend_i | input | NUM_IRQ | Pending request per interrupt ID |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Fixed priority per ID, ID n in bits n*PRIO_W +: PRIO_W |
| req_i | input | 1 | Bus access request, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte offset in the 8 KB register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | High one cycle after a read request |
| irq_o | output | 1 | Interrupt signal to the processor |

## Verification
The hardest state to reach is the split-mode gap. In that window an interrupt has been dropped but is still active, and a second request at the same priority is pending. Reaching it takes an acknowledge, a drop and a further acknowledge, all in split mode, and then a deactivate to release the first interrupt. The stimulus walks through that sequence with several same-priority IDs held pending, and then repeats the deactivate with split mode off to show it is ignored. The stack-full boundary is reached by raising four requests one at a time, each at a higher priority than the last, and acknowledging each in turn.

// File: rtl/irq_cpu_pkg.sv
`timescale 1ns/1ps
package irq_cpu_pkg;
    localparam int ADDR_W = 13;
    localparam int ID_W   = 10;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 13'h0000;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 13'h000C;
    localparam logic [ADDR_W-1:0] OFF_DROP  = 13'h0010;
    localparam logic [ADDR_W-1:0] OFF_DEACT = 13'h1000;

    localparam logic [ID_W-1:0] ID_SPURIOUS = 10'd1023;
    localparam logic [ID_W-1:0] ID_RESERVED = 10'd1020;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_SPLIT_BIT = 9;
    localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_03E1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } run_state_e;
endpackage

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]        elig_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output logic                      found_o,
    output logic [IDX_W-1:0]          win_idx_o,
    output logic [PRIO_W-1:0]         win_prio_o
);
    logic [PRIO_W-1:0] prio_arr [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // Ascending scan with a strict compare: on a tie the earlier (lower) ID stays.
    always_comb begin
        found_o    = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig_i[i] && (!found_o || (prio_arr[i] < win_prio_o))) begin
                found_o    = 1'b1;
                win_idx_o  = IDX_W'(i);
                win_prio_o = prio_arr[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_stack.sv
`timescale 1ns/1ps
module irq_prio_stack #(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 10,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic [ID_W-1:0]   push_id_i,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [ID_W-1:0]   top_id_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              empty_o,
    output logic              full_o
);
    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [ID_W-1:0]   id_mem   [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  top_ptr;

    assign wr_ptr  = PTR_W'(cnt_q);
    assign top_ptr = PTR_W'(cnt_q - 1'b1);
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign count_o = cnt_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_mem[k] <= '0;
                id_mem[k]   <= '0;
            end else if (push_i && !full_o && (wr_ptr == PTR_W'(k))) begin
                prio_mem[k] <= push_prio_i;
                id_mem[k]   <= push_id_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push_i && !full_o)
            cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !empty_o)
            cnt_q <= cnt_q - 1'b1;
    end

    assign top_prio_o = empty_o ? '0 : prio_mem[top_ptr];
    assign top_id_o   = empty_o ? '0 : id_mem[top_ptr];

    // R5: the interface never pushes into a full stack
    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R9: a drop only pops when something is there
    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/irq_cpu_if.sv
`timescale 1ns/1ps
module irq_cpu_if
    import irq_cpu_pkg::*;
#(
    parameter int NUM_IRQ     = 32,
    parameter int PRIO_W      = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic                      req_i,
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [31:0]               wdata_i,
    output logic [31:0]               rdata_o,
    output logic                      rvalid_o,
    output logic                      irq_o
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);
    localparam int RP_W  = PRIO_W + 1;
    localparam logic [RP_W-1:0] IDLE_PRIO = RP_W'(1 << PRIO_W);

    run_state_e         state_q, state_d;
    logic [31:0]        ctrl_q;
    logic [NUM_IRQ-1:0] active_q, active_d;
    logic [NUM_IRQ-1:0] elig;
    logic [RP_W-1:0]    run_prio;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic [PRIO_W-1:0]  top_prio;
    logic [ID_W-1:0]    top_id;
    logic [CNT_W-1:0]   stk_cnt;
    logic               stk_empty, stk_full;
    logic               en, split;
    logic               take_ok, rd_req, rd_ack, ack_take;
    logic               drop_wr, drop_match, deact_wr, deact_hit;
    logic [ID_W-1:0]    wr_id;
    logic [IDX_W-1:0]   drop_idx, deact_idx;
    logic [31:0]        rdata_q;
    logic               rvalid_q;

    assign en    = ctrl_q[CTRL_EN_BIT];
    assign split = ctrl_q[CTRL_SPLIT_BIT];
    assign wr_id = wdata_i[ID_W-1:0];

    // ---------------- eligibility and selection ----------------
    assign run_prio = (state_q == ST_IDLE) ? IDLE_PRIO : {1'b0, top_prio};

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
        assign elig[g] = irq_pend_i[g] && !active_q[g] &&
                         ({1'b0, irq_prio_i[g*PRIO_W +: PRIO_W]} < run_prio);
    end

    irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .elig_i     (elig),
        .prio_i     (irq_prio_i),
        .found_o    (found),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    // ---------------- bus decode ----------------
    assign rd_req     = req_i && !wr_i;
    assign rd_ack     = rd_req && (addr_i == OFF_ACK);
    assign ack_take   = rd_ack && take_ok;
    assign drop_wr    = req_i && wr_i && (addr_i == OFF_DROP);
    assign drop_match = drop_wr && (state_q != ST_IDLE) && (wr_id == top_id);
    assign drop_idx   = top_id[IDX_W-1:0];
    assign deact_wr   = req_i && wr_i && (addr_i == OFF_DEACT) && split;
    assign deact_idx  = wr_id[IDX_W-1:0];
    assign deact_hit  = deact_wr && (wr_id < ID_W'(NUM_IRQ)) && active_q[deact_idx];

    irq_prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ack_take),
        .pop_i       (drop_match),
        .push_prio_i (win_prio),
        .push_id_i   (ID_W'(win_idx)),
        .top_prio_o  (top_prio),
        .top_id_o    (top_id),
        .count_o     (stk_cnt),
        .empty_o     (stk_empty),
        .full_o      (stk_full)
    );

    // ---------------- nesting state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_take)
                    state_d = (STACK_DEPTH == 1) ? ST_FULL : ST_NESTED;
            end
            ST_NESTED: begin
                if (ack_take && (stk_cnt == CNT_W'(STACK_DEPTH - 1)))
                    state_d = ST_FULL;
                else if (drop_match && (stk_cnt == CNT_W'(1)))
                    state_d = ST_IDLE;
            end
            ST_FULL: begin
                if (drop_match)
                    state_d = (STACK_DEPTH == 1) ? ST_IDLE : ST_NESTED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process: the line is signalled only where a take is allowed
    always_comb begin
        take_ok = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_NESTED: take_ok = en && found;
            ST_FULL:            take_ok = 1'b0;
            default:            take_ok = 1'b0;
        endcase
    end
    assign irq_o = take_ok;

    // ---------------- active set ----------------
    always_comb begin
        active_d = active_q;
        if (ack_take)
            active_d[win_idx] = 1'b1;
        if (drop_match && !split)
            active_d[drop_idx] = 1'b0;
        if (deact_hit)
            active_d[deact_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= '0;
        else        active_q <= active_d;
    end

    // ---------------- registers and read path ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (req_i && wr_i && (addr_i == OFF_CTRL))
            ctrl_q <= wdata_i & CTRL_KEEP_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_req;
            if (rd_req) begin
                case (addr_i)
                    OFF_CTRL: rdata_q <= ctrl_q;
                    OFF_ACK:  rdata_q <= {22'd0, ack_take ? ID_W'(win_idx) : ID_SPURIOUS};
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    // ---------------- assertions ----------------
    // R2: nothing is signalled while the interface is disabled
    a_r2_irq_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTRL_EN_BIT] |-> !irq_o);
    // R4: the reserved ID never comes back from a read
    a_r4_no_reserved_id: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (rdata_o[ID_W-1:0] != ID_RESERVED));
    // R4: a real ID returned by acknowledge is active when it appears
    a_r4_ack_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && $past(rd_ack) && (rdata_o[ID_W-1:0] != ID_SPURIOUS))
        |-> active_q[rdata_o[IDX_W-1:0]]);
    // R5: each push raises the running priority strictly
    a_r5_push_raises_prio: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (run_prio < $past(run_prio)));
    // R5: the state machine agrees with the stack occupancy
    a_r5_state_tracks_depth: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) == stk_empty) && ((state_q == ST_FULL) == stk_full));
    // R6: a drop with split off frees the interrupt
    a_r6_drop_deactivates: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_match && !split) |=> !active_q[$past(drop_idx)]);
    // R7: a drop with split on leaves it active
    a_r7_split_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_match && split) |=> active_q[$past(drop_idx)]);
endmodule

// File: tb/irq_cpu_if_tb.sv
`timescale 1ns/1ps
module irq_cpu_if_tb;
    localparam int NUM_IRQ = 32;
    localparam int PRIO_W  = 4;
    localparam logic [12:0] A_CTRL  = 13'h0000;
    localparam logic [12:0] A_ACK   = 13'h000C;
    localparam logic [12:0] A_DROP  = 13'h0010;
    localparam logic [12:0] A_DEACT = 13'h1000;
    localparam int SPUR = 1023;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_IRQ-1:0]        pend = '0;
    logic [PRIO_W-1:0]         prio_t [NUM_IRQ];
    logic [NUM_IRQ*PRIO_W-1:0] prio_bus;
    logic                      req = 1'b0, wr = 1'b0;
    logic [12:0]               addr = '0;
    logic [31:0]               wdata = '0;
    logic [31:0]               rdata_o;
    logic                      rvalid_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int    exp_q [$];
    string tag_q [$];

    always #2 clk = ~clk;

    always_comb
        for (int i = 0; i < NUM_IRQ; i++) prio_bus[i*PRIO_W +: PRIO_W] = prio_t[i];

    irq_cpu_if #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .STACK_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend_i(pend), .irq_prio_i(prio_bus),
        .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o)
    );

    // Monitor: compare each read response against the scoreboard
    always @(negedge clk) begin
        if (rvalid_o) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read response: actual %0d expected none", rdata_o);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata_o !== 32'(e)) begin
                    n_fail++;
                    $display("FAIL %s: read actual %0d expected %0d", t, rdata_o, e);
                end
            end
        end
    end

    task automatic rd(input logic [12:0] a, input int e, input string t);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wrt(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        #1;
        n_checks++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s: irq_o actual %0b expected %0b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) prio_t[i] = 4'd15;
        prio_t[20] = 4'd5; prio_t[17] = 4'd5; prio_t[25] = 4'd7;
        prio_t[9]  = 4'd4; prio_t[3]  = 4'd2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_CTRL, 0, "R1 ctrl after reset");
        rd(A_ACK, SPUR, "R1 ack after reset");

        // R2 disabled interface
        @(negedge clk); pend[20] = 1'b1;
        chk_irq(1'b0, "R2 disabled");
        rd(A_ACK, SPUR, "R2 ack while disabled");

        // R10 control readback mask
        wrt(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h3E1, "R10 ctrl mask");
        wrt(A_CTRL, 32'h1);
        chk_irq(1'b1, "R2 enabled");

        // R3 tie break, R5 equal priority does not preempt
        @(negedge clk); pend[17] = 1'b1; pend[25] = 1'b1;
        rd(A_ACK, 17, "R3 lower id wins tie");
        chk_irq(1'b0, "R5 equal prio blocked");
        rd(A_ACK, SPUR, "R5 nothing higher");
        @(negedge clk); pend[9] = 1'b1;
        chk_irq(1'b1, "R5 higher prio preempts");
        @(negedge clk); pend[3] = 1'b1;
        rd(A_ACK, 3, "R3 highest prio wins");
        @(negedge clk); pend[3] = 1'b0;

        // R9 mismatched drop ignored
        wrt(A_DROP, 32'd17);
        rd(A_ACK, SPUR, "R9 mismatched drop ignored");

        // R6 combined mode
        wrt(A_DROP, 32'd3);
        chk_irq(1'b1, "R6 drop lowers running prio");
        rd(A_ACK, 9, "R6 next taken");
        @(negedge clk); pend[9] = 1'b0;
        wrt(A_DROP, 32'd9);
        wrt(A_DROP, 32'd17);
        rd(A_ACK, 17, "R6 drop deactivates");
        wrt(A_DROP, 32'd17);

        // R7 split mode
        wrt(A_CTRL, 32'h201);
        rd(A_ACK, 17, "R7 first taken");
        wrt(A_DROP, 32'd17);
        rd(A_ACK, 20, "R7 same prio taken after drop");
        wrt(A_DROP, 32'd20);
        rd(A_ACK, 25, "R7 lower prio after drops");
        wrt(A_DROP, 32'd25);
        chk_irq(1'b0, "R7 dropped ones stay active");
        rd(A_ACK, SPUR, "R7 nothing retaken");

        // R8 deactivate
        wrt(A_DEACT, 32'd17);
        chk_irq(1'b1, "R8 deactivate frees");
        rd(A_ACK, 17, "R8 retaken after deactivate");
        wrt(A_DROP, 32'd17);
        @(negedge clk); pend[17] = 1'b0;
        wrt(A_DEACT, 32'd17);
        wrt(A_DEACT, 32'd17);
        wrt(A_CTRL, 32'h1);
        wrt(A_DEACT, 32'd20);
        chk_irq(1'b0, "R8 deactivate ignored in combined mode");
        rd(A_ACK, SPUR, "R8 still active in combined mode");
        wrt(A_CTRL, 32'h201);
        wrt(A_DEACT, 32'd20);
        chk_irq(1'b1, "R8 deactivate in split mode");
        rd(A_ACK, 20, "R8 retaken in split mode");
        wrt(A_DROP, 32'd20);
        @(negedge clk); pend = '0;
        wrt(A_DEACT, 32'd20);
        wrt(A_DEACT, 32'd25);

        // R5 stack full
        prio_t[30] = 4'd12; prio_t[29] = 4'd10; prio_t[28] = 4'd8;
        prio_t[27] = 4'd6;  prio_t[26] = 4'd1;
        @(negedge clk); pend[30] = 1'b1;
        rd(A_ACK, 30, "R5 nest level 1");
        @(negedge clk); pend[29] = 1'b1;
        rd(A_ACK, 29, "R5 nest level 2");
        @(negedge clk); pend[28] = 1'b1;
        rd(A_ACK, 28, "R5 nest level 3");
        @(negedge clk); pend[27] = 1'b1;
        rd(A_ACK, 27, "R5 nest level 4");
        @(negedge clk); pend[26] = 1'b1;
        chk_irq(1'b0, "R5 full stack blocks irq");
        rd(A_ACK, SPUR, "R5 full stack ack");
        wrt(A_DROP, 32'd27);
        chk_irq(1'b1, "R5 slot freed");
        rd(A_ACK, 26, "R5 taken after slot freed");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 responses missing: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule